// File: doc/BRIEF.md
# Serial Frame Receiver with Run-Time Parity

This block recovers characters from an asynchronous serial line. The line idles high. A frame opens with a low start bit, carries a parameterised number of data bits with the least significant bit first, may carry one parity bit, and closes with a high stop bit. The ratio of clock frequency to baud rate sets the bit period in clock cycles. Both values are parameters, and the clock is nominally 50 MHz.

Two level inputs set the framing at run time. One adds or removes the parity bit, and the other picks odd or even parity. The block latches both when it accepts a start bit. It shortens or lengthens the frame to match, so no rebuild is needed when a link changes its settings. On the clock after the stop bit is sampled, the character appears on the data output together with a one-cycle done pulse. Parity and stop-bit faults are reported on an error line that pulses in the same cycle as done.

Top module: `uart_rx_par`

## Requirements
- R1: While reset is held and on the first clock after it, `rx_data` is all zeros and `rx_done` and `rx_err` are 0.
- R2: For each frame, `rx_data` carries the data bits in arrival order, with the first bit in bit 0. It is updated in the same cycle as the single `rx_done` pulse for that frame.
- R3: With `par_en` = 0, a frame is start, DW data bits, then stop. A following frame whose start bit begins right after the stop bit is also received.
- R4: With `par_en` = 1 and `par_odd` = 0, one parity bit follows the data. `rx_err` pulses unless the data bits and parity bit together hold an even number of ones.
- R5: With `par_en` = 1 and `par_odd` = 1, `rx_err` pulses unless the data bits and parity bit together hold an odd number of ones.
- R6: A stop bit sampled low makes `rx_err` pulse with `rx_done`. The data byte is still presented.
- R7: A low pulse shorter than half a bit period on an idle line produces no `rx_done`, and the block is then ready for the next frame.
- R8: `par_en` and `par_odd` are taken when the start bit is detected. Changing them later in the frame does not change that frame's length or its check.
- R9: `rx_done` never stays high for two consecutive cycles, and `rx_err` is high only while `rx_done` is high.
- R10: `rx_data` keeps its value in every cycle without `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_data | output | DW | Last received character |
| rx_done | output | 1 | One-cycle pulse when a character is complete |
| rx_err | output | 1 | Pulses with rx_done on a parity or stop fault |

## Verification
The properties assume that the serial line drives whole bits at the configured bit period. The framing controls may change at any time, and the block latches them per frame. The stimulus holds each bit for exactly the parameterised number of clock cycles, and it leaves the line high between frames, except in the back-to-back case. The glitch case uses a low pulse of two cycles, which is well under half a bit. The mid-frame control flips happen only after the start bit, so they test the latching rather than a change that races the start edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= d_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
   parameter int BIT_CYC = 434
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic half_hit,
   output logic full_hit
);
   localparam int CW   = $clog2(BIT_CYC + 1);
   localparam int HALF = BIT_CYC / 2;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;

   assign half_hit = (cnt_q == CW'(HALF - 1));
   assign full_hit = (cnt_q == CW'(BIT_CYC - 1));
endmodule

// File: rtl/uart_rx_par.sv
module uart_rx_par #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BAUD        = 115_200,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rxd,
   input  logic          par_en,
   input  logic          par_odd,
   output logic [DW-1:0] rx_data,
   output logic          rx_done,
   output logic          rx_err
);
   import uart_rx_pkg::*;

   localparam int BIT_CYC = CLK_HZ / BAUD;
   localparam int IW      = (DW > 1) ? $clog2(DW) : 1;

   generate
      if (BIT_CYC < 4) begin : g_bad_ratio
         $error("uart_rx_par: CLK_HZ/BAUD must be at least 4");
      end
      if (DW < 5 || DW > 9) begin : g_bad_dw
         $error("uart_rx_par: DW must lie in 5..9");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_rx_par: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          rx_s, rx_prev_q;
   logic          half_hit, full_hit, tmr_clr;
   rx_state_t     state_q;
   logic [IW-1:0] idx_q;
   logic [DW-1:0] shift_q;
   logic          pen_q, podd_q, perr_q;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(rx_s)
   );

   uart_rx_timer #(.BIT_CYC(BIT_CYC)) tmr_i (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
      .half_hit(half_hit), .full_hit(full_hit)
   );

   always_comb begin
      unique case (state_q)
         ST_IDLE:  tmr_clr = 1'b1;
         ST_START: tmr_clr = half_hit;
         default:  tmr_clr = full_hit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rx_prev_q <= 1'b1;
         idx_q     <= '0;
         shift_q   <= '0;
         pen_q     <= 1'b0;
         podd_q    <= 1'b0;
         perr_q    <= 1'b0;
         rx_data   <= '0;
         rx_done   <= 1'b0;
         rx_err    <= 1'b0;
      end else begin
         rx_prev_q <= rx_s;
         rx_done   <= 1'b0;
         rx_err    <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (rx_prev_q && !rx_s) begin
                  state_q <= ST_START;
                  pen_q   <= par_en;
                  podd_q  <= par_odd;
                  perr_q  <= 1'b0;
                  idx_q   <= '0;
               end
            end
            ST_START: begin
               if (half_hit) state_q <= rx_s ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
               if (full_hit) begin
                  shift_q <= {rx_s, shift_q[DW-1:1]};
                  idx_q   <= idx_q + 1'b1;
                  if (idx_q == IW'(DW - 1))
                     state_q <= pen_q ? ST_PAR : ST_STOP;
               end
            end
            ST_PAR: begin
               if (full_hit) begin
                  perr_q  <= ((^shift_q) ^ rx_s) != podd_q;
                  state_q <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (full_hit) begin
                  rx_data <= shift_q;
                  rx_done <= 1'b1;
                  rx_err  <= perr_q | !rx_s;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_par_chk.sv
module uart_rx_par_chk #(
   parameter int DW = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rx_done,
   input logic                  rx_err,
   input logic [DW-1:0]         rx_data,
   input uart_rx_pkg::rx_state_t state_q,
   input logic                  pen_q,
   input logic                  podd_q
);
   import uart_rx_pkg::*;

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> rx_done);

   a_r2_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(state_q) == ST_STOP);

   a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |-> $stable(rx_data));

   a_r8_cfg_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
         |-> ($stable(pen_q) && $stable(podd_q)));
endmodule

bind uart_rx_par uart_rx_par_chk #(.DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_err(rx_err),
   .rx_data(rx_data), .state_q(state_q), .pen_q(pen_q), .podd_q(podd_q)
);

// File: tb/uart_rx_par_tb_top.sv
module uart_rx_par_tb_top;
   localparam int DW      = 8;
   localparam int CLK_HZ  = 50_000_000;
   localparam int BAUD    = 5_000_000;
   localparam int BIT_CYC = CLK_HZ / BAUD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rxd = 1'b1;
   logic          par_en = 1'b0;
   logic          par_odd = 1'b0;
   logic [DW-1:0] rx_data;
   logic          rx_done, rx_err;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [DW-1:0] exp_d[$];
   logic          exp_e[$];
   string         exp_t[$];
   logic          prev_done = 1'b0;
   logic [DW-1:0] last_d = '0;

   always #2 clk = ~clk;

   uart_rx_par #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DW(DW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .par_en(par_en), .par_odd(par_odd),
      .rx_data(rx_data), .rx_done(rx_done), .rx_err(rx_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference model: every clock, compare outputs with the queue of expected characters
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (rx_done) begin
            chk(!prev_done, "R9 done one cycle", 1, 0);
            if (exp_d.size() == 0) begin
               chk(1'b0, "R7 unexpected done", rx_data, 0);
            end else begin
               chk(rx_data == exp_d[0], {exp_t[0], " data R2"}, rx_data, exp_d[0]);
               chk(rx_err == exp_e[0], {exp_t[0], " err"}, rx_err, exp_e[0]);
               last_d = exp_d[0];
               void'(exp_d.pop_front());
               void'(exp_e.pop_front());
               void'(exp_t.pop_front());
            end
         end else begin
            if (rx_err) chk(1'b0, "R9 err without done", 1, 0);
            if (rx_data != last_d) chk(1'b0, "R10 data held", rx_data, last_d);
         end
         prev_done = rx_done;
      end
   end

   task automatic drive_bit(input logic v);
      rxd = v;
      repeat (BIT_CYC) @(posedge clk);
      #1;
   endtask

   task automatic send(input logic [DW-1:0] d, input bit pen, input bit podd,
                       input bit bad_par, input logic stop_v, input bit flip,
                       input int idle_bits, input string tag);
      logic pbit;
      pbit = podd ? ~(^d) : (^d);
      if (bad_par) pbit = ~pbit;
      exp_d.push_back(d);
      exp_e.push_back((pen && bad_par) || !stop_v);
      exp_t.push_back(tag);
      par_en = pen;
      par_odd = podd;
      drive_bit(1'b0);
      if (flip) begin
         par_en = ~pen;
         par_odd = ~podd;
      end
      for (int i = 0; i < DW; i++) drive_bit(d[i]);
      if (pen) drive_bit(pbit);
      drive_bit(stop_v);
      rxd = 1'b1;
      for (int i = 0; i < idle_bits; i++) drive_bit(1'b1);
      par_en = pen;
      par_odd = podd;
   endtask

   task automatic expect_drained(input string tag);
      repeat (2 * BIT_CYC) @(posedge clk);
      #1;
      chk(exp_d.size() == 0, {tag, " frame delivered"}, exp_d.size(), 0);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         finished = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(rx_data == '0, "R1 data reset", rx_data, 0);
      chk(rx_done == 1'b0, "R1 done reset", rx_done, 0);
      chk(rx_err == 1'b0, "R1 err reset", rx_err, 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(rx_done == 1'b0 && rx_err == 1'b0, "R1 first clock", rx_done, 0);
      repeat (5 * BIT_CYC) @(posedge clk);
      #1;

      send(8'hA5, 0, 0, 0, 1'b1, 0, 1, "R3 no parity");
      expect_drained("R3");
      send(8'h3C, 1, 0, 0, 1'b1, 0, 1, "R4 even ok");
      send(8'h07, 1, 0, 1, 1'b1, 0, 1, "R4 even bad");
      expect_drained("R4");
      send(8'h3C, 1, 1, 0, 1'b1, 0, 1, "R5 odd ok");
      send(8'hFF, 1, 1, 1, 1'b1, 0, 1, "R5 odd bad");
      expect_drained("R5");
      send(8'h5A, 0, 0, 0, 1'b0, 0, 1, "R6 stop low");
      send(8'hC3, 1, 0, 0, 1'b0, 0, 1, "R6 stop low parity");
      expect_drained("R6");
      send(8'h01, 0, 0, 0, 1'b1, 0, 0, "R3 back-to-back a");
      send(8'h80, 0, 0, 0, 1'b1, 0, 1, "R3 back-to-back b");
      expect_drained("R3 b2b");

      // R7: short low glitch on an idle line
      rxd = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rxd = 1'b1;
      repeat (3 * BIT_CYC) @(posedge clk);
      #1;
      chk(exp_d.size() == 0, "R7 glitch no done", exp_d.size(), 0);
      send(8'h77, 1, 1, 0, 1'b1, 0, 1, "R7 after glitch");
      expect_drained("R7");

      send(8'h96, 1, 0, 1, 1'b1, 1, 1, "R8 on->off mid");
      send(8'h42, 0, 1, 0, 1'b1, 1, 1, "R8 off->on mid");
      expect_drained("R8");

      repeat (4 * BIT_CYC) @(posedge clk);
      #1;
      chk(rx_data == 8'h42, "R10 data held idle", rx_data, 8'h42);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule